// File: doc/BRIEF.md
# Eight-Channel Parallel Converter Write Sequencer

This block sits between a host that issues channel updates and a bank of eight converter latches that share one 8-bit data bus, a 3-bit channel select and an active-low write strobe. Each latch is level-sensitive. While the strobe is low, the selected latch is open and follows the bus. The latch closes on the rising edge of the strobe. While the strobe is high, every latch keeps its code. The sequencer turns each accepted host request into a complete strobe cycle. That cycle meets the minimum low width, the data setup time before the rising edge, and the data and address hold time after it. All of these times are given in nanoseconds and converted to clock cycles when the design is elaborated.

The host presents a channel index, an 8-bit straight-binary code and a broadcast flag on a valid/ready handshake. A broadcast request writes the one code to every channel in ascending order, as back-to-back complete write cycles. A shadow bank keeps the last code that completed on each channel. The host can read the shadow bank at any time through a separate channel index.

Top module: `dac8_write_seq`

## Requirements
- R1: While reset is asserted, and immediately after it, the strobe is high, ready is high and every shadow entry reads zero. Asserting reset in the middle of a sequence abandons that sequence.
- R2: Each strobe low pulse lasts exactly LOW_N clock cycles. LOW_N is the larger of ceil(low-width ns / clock ns) and ceil(data-setup ns / clock ns), and is at least 1.
- R3: The address and data are driven at least one cycle before the strobe falls. They do not change while the strobe is low.
- R4: After the strobe rises, the address and data stay unchanged for HOLD_N cycles, where HOLD_N = max(1, ceil(hold ns / clock ns)).
- R5: Address value k selects channel k, for k from 0 to 7 in binary. After a single write, only that channel's latch holds the new code. All other latches are unchanged.
- R6: A request is accepted when valid and ready are both high at a clock edge. Ready then stays low for exactly 1 + LOW_N + HOLD_N cycles for a single write.
- R7: A broadcast request writes its code to addresses 0 through 7 in ascending order. It makes eight complete strobe cycles, and ready stays low for eight times the single-write length.
- R8: When a write's hold interval ends, the shadow entry for that channel takes the written code. The read port returns the entry selected by the read index.
- R9: The channel field of a broadcast request is ignored. The broadcast always starts at address 0.
- R10: A later write to the same channel replaces that channel's code in both the latch and the shadow bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_chan | input | 3 | Target channel index |
| req_code | input | 8 | Straight-binary code to write |
| req_bcast | input | 1 | Write the code to every channel |
| dac_addr | output | 3 | Channel select to the latches |
| dac_data | output | 8 | Shared data bus to the latches |
| dac_wr_n | output | 1 | Active-low write strobe |
| rd_chan | input | 3 | Shadow read index |
| rd_code | output | 8 | Shadow code for rd_chan |

## Verification
The hardest case to reach from the ports is the boundary between two broadcast writes. There, the address moves to the next channel just as the previous hold window expires. If this happens one cycle early, the channel that was just written is corrupted through its still-open latch path. The testbench models the eight transparent latches itself and sends a broadcast with a non-zero channel field. It then checks every latch, the shadow bank, the order of the captured addresses and the absence of hold violations across the seven internal boundaries. A reset asserted in the middle of a broadcast covers the abandoned-sequence case.

// File: rtl/dac8_seq_pkg.sv
package dac8_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LOW   = 2'd2,
    ST_HOLD  = 2'd3
  } seq_state_e;

  // convert a nanosecond minimum into whole clock cycles, never less than one
  function automatic int ns_to_cyc(input int ns, input int per_ns);
    int c;
    c = (ns + per_ns - 1) / per_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac8_seq_shadow.sv
module dac8_seq_shadow #(
  parameter int CH_CNT = 8,
  parameter int CODE_W = 8,
  localparam int AW = $clog2(CH_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [CODE_W-1:0] rdata
);

  logic [CODE_W-1:0] ent_q [CH_CNT];

  for (genvar g = 0; g < CH_CNT; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= wdata;
    end
  end

  assign rdata = ent_q[raddr];

  // R8: a committed write is visible in the addressed entry on the next cycle
  assert_shadow_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ent_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/dac8_seq_ctrl.sv
module dac8_seq_ctrl
  import dac8_seq_pkg::*;
#(
  parameter int CH_CNT = 8,
  parameter int CODE_W = 8,
  parameter int LOW_N  = 30,
  parameter int HOLD_N = 2,
  localparam int AW    = $clog2(CH_CNT),
  localparam int CNT_W = $clog2(max_int(LOW_N, HOLD_N) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_chan,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_bcast,
  output logic [AW-1:0]     dac_addr,
  output logic [CODE_W-1:0] dac_data,
  output logic              dac_wr_n,
  output logic              cmt_we,
  output logic [AW-1:0]     cmt_addr,
  output logic [CODE_W-1:0] cmt_code
);

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              bc_q, bc_d;
  logic              wr_n_q, wr_n_d;
  logic              last_ch;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign last_ch  = (addr_q == AW'(CH_CNT - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    code_d = code_q;
    bc_d   = bc_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          addr_d = req_bcast ? '0 : req_chan;
          code_d = req_code;
          bc_d   = req_bcast;
          st_d   = ST_SETUP;
        end
      end
      ST_SETUP: begin
        st_d  = ST_LOW;
        cnt_d = CNT_W'(LOW_N - 1);
      end
      ST_LOW: begin
        if (cnt_zero) begin
          st_d  = ST_HOLD;
          cnt_d = CNT_W'(HOLD_N - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt_zero) begin
          if (bc_q && !last_ch) begin
            addr_d = addr_q + 1'b1;
            st_d   = ST_SETUP;
          end else begin
            bc_d = 1'b0;
            st_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    wr_n_d = (st_d != ST_LOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      code_q <= '0;
      bc_q   <= 1'b0;
      wr_n_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      code_q <= code_d;
      bc_q   <= bc_d;
      wr_n_q <= wr_n_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign dac_addr  = addr_q;
  assign dac_data  = code_q;
  assign dac_wr_n  = wr_n_q;
  assign cmt_we    = (st_q == ST_HOLD) && cnt_zero;
  assign cmt_addr  = addr_q;
  assign cmt_code  = code_q;

  // checker: length of the current strobe low run
  logic [CNT_W:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run_q <= '0;
    else if (!wr_n_q)  low_run_q <= low_run_q + 1'b1;
    else               low_run_q <= '0;
  end

  // R1: no strobe pulse while the host side is idle
  assert_idle_strobe_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> dac_wr_n);

  // R2: each low pulse is exactly LOW_N cycles long
  assert_low_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> (low_run_q == (CNT_W+1)'(LOW_N)));

  // R3: bus already settled when the strobe falls
  assert_setup_before_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_wr_n) |-> ($stable(dac_addr) && $stable(dac_data)));

  // R3: bus steady through the low period
  assert_stable_while_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_wr_n && !$past(dac_wr_n)) |-> ($stable(dac_addr) && $stable(dac_data)));

  // R4: bus unchanged on the rising edge
  assert_hold_at_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> ($stable(dac_addr) && $stable(dac_data)));

  // R6: acceptance makes the sequencer busy
  assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: rtl/dac8_write_seq.sv
module dac8_write_seq
  import dac8_seq_pkg::*;
#(
  parameter int CH_CNT     = 8,
  parameter int CODE_W     = 8,
  parameter int CLK_NS     = 5,
  parameter int T_LOW_NS   = 150,
  parameter int T_DSU_NS   = 100,
  parameter int T_DH_NS    = 10,
  localparam int AW        = $clog2(CH_CNT),
  localparam int LOW_N     = max_int(ns_to_cyc(T_LOW_NS, CLK_NS), ns_to_cyc(T_DSU_NS, CLK_NS)),
  localparam int HOLD_N    = ns_to_cyc(T_DH_NS, CLK_NS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_chan,
  input  logic [CODE_W-1:0] req_code,
  input  logic              req_bcast,
  output logic [AW-1:0]     dac_addr,
  output logic [CODE_W-1:0] dac_data,
  output logic              dac_wr_n,
  input  logic [AW-1:0]     rd_chan,
  output logic [CODE_W-1:0] rd_code
);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic              cmt_we;
  logic [AW-1:0]     cmt_addr;
  logic [CODE_W-1:0] cmt_code;

  dac8_seq_ctrl #(
    .CH_CNT (CH_CNT),
    .CODE_W (CODE_W),
    .LOW_N  (LOW_N),
    .HOLD_N (HOLD_N)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_chan  (req_chan),
    .req_code  (req_code),
    .req_bcast (req_bcast),
    .dac_addr  (dac_addr),
    .dac_data  (dac_data),
    .dac_wr_n  (dac_wr_n),
    .cmt_we    (cmt_we),
    .cmt_addr  (cmt_addr),
    .cmt_code  (cmt_code)
  );

  dac8_seq_shadow #(
    .CH_CNT (CH_CNT),
    .CODE_W (CODE_W)
  ) u_shadow (
    .clk   (clk),
    .rst_n (rst_n_int),
    .we    (cmt_we),
    .waddr (cmt_addr),
    .wdata (cmt_code),
    .raddr (rd_chan),
    .rdata (rd_code)
  );

endmodule

// File: tb/tb_dac8_write_seq.sv
module tb_dac8_write_seq;

  localparam int P_NS = 5, TLOW = 150, TDSU = 100, TDH = 10;
  localparam int C_LOW  = (TLOW + P_NS - 1) / P_NS;
  localparam int C_DSU  = (TDSU + P_NS - 1) / P_NS;
  localparam int LOW_E  = (C_LOW > C_DSU) ? C_LOW : C_DSU;
  localparam int HOLD_E = ((TDH + P_NS - 1) / P_NS < 1) ? 1 : (TDH + P_NS - 1) / P_NS;
  localparam int WCYC   = 1 + LOW_E + HOLD_E;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_bcast = 0;
  logic [2:0] req_chan = 0, rd_chan = 0;
  logic [7:0] req_code = 0;
  logic req_ready, dac_wr_n;
  logic [2:0] dac_addr;
  logic [7:0] dac_data, rd_code;

  always #2.5 clk = ~clk;

  dac8_write_seq #(.CLK_NS(P_NS), .T_LOW_NS(TLOW), .T_DSU_NS(TDSU), .T_DH_NS(TDH)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_code(req_code), .req_bcast(req_bcast),
    .dac_addr(dac_addr), .dac_data(dac_data), .dac_wr_n(dac_wr_n),
    .rd_chan(rd_chan), .rd_code(rd_code));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model of the eight level-sensitive latches plus timing monitor
  logic [7:0] lat [8];
  logic [7:0] exp_code [8];
  int low_run = 0, low_min = 1 << 20, low_max = 0, pulses = 0;
  int since_rise = 0, setup_viol = 0, low_viol = 0, hold_viol = 0;
  logic prev_wr_n = 1;
  logic [2:0] prev_addr = 0;
  logic [7:0] prev_data = 0;
  logic [2:0] cap_log [32];
  int cap_n = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_wr_n <= 1; low_run <= 0; since_rise <= 0;
    end else begin
      if (!dac_wr_n) begin
        lat[dac_addr] = dac_data;
        if (prev_wr_n && (dac_addr != prev_addr || dac_data != prev_data)) setup_viol++;
        if (!prev_wr_n && (dac_addr != prev_addr || dac_data != prev_data)) low_viol++;
        low_run = low_run + 1;
      end else begin
        if (!prev_wr_n) begin
          pulses++;
          if (low_run < low_min) low_min = low_run;
          if (low_run > low_max) low_max = low_run;
          if (cap_n < 32) cap_log[cap_n] = prev_addr;
          cap_n++;
          low_run = 0;
          since_rise = 0;
        end
        since_rise = since_rise + 1;
        if (since_rise <= HOLD_E && (dac_addr != prev_addr || dac_data != prev_data)) hold_viol++;
      end
      prev_wr_n = dac_wr_n; prev_addr = dac_addr; prev_data = dac_data;
    end
  end

  task automatic send(input logic bc, input logic [2:0] ch, input logic [7:0] cd, output int busy);
    @(negedge clk);
    req_valid = 1; req_bcast = bc; req_chan = ch; req_code = cd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    busy = 0;
    while (!req_ready) begin busy++; @(negedge clk); end
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 8; k++) begin
      chk({req, " latch"}, lat[k], exp_code[k]);
      rd_chan = 3'(k);
      #0.1;
      chk({req, " shadow"}, rd_code, exp_code[k]);
    end
  endtask

  // stimulus table: {bcast, chan, code, expected busy cycles}
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'hA5, 16'(WCYC)},
    {1'b0, 3'd7, 8'hFF, 16'(WCYC)},
    {1'b0, 3'd3, 8'h00, 16'(WCYC)},
    {1'b0, 3'd5, 8'h80, 16'(WCYC)},
    {1'b0, 3'd5, 8'h7F, 16'(WCYC)},
    {1'b0, 3'd1, 8'h01, 16'(WCYC)},
    {1'b1, 3'd5, 8'h3C, 16'(8*WCYC)},
    {1'b0, 3'd6, 8'hC3, 16'(WCYC)}
  };

  initial begin
    for (int k = 0; k < 8; k++) begin lat[k] = 8'hEE; exp_code[k] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 strobe in reset", dac_wr_n, 1);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 strobe after reset", dac_wr_n, 1);
    for (int k = 0; k < 8; k++) begin
      rd_chan = 3'(k); #0.1;
      chk("R1 shadow zero", rd_code, 0);
    end
    for (int k = 0; k < 8; k++) exp_code[k] = 8'hEE; // latches untouched so far

    for (int v = 0; v < NV; v++) begin
      int busy;
      logic [27:0] e;
      e = VEC[v];
      send(e[27], e[26:24], e[23:16], busy);
      if (e[27]) begin
        // R7 R9 broadcast to all channels regardless of chan field
        for (int k = 0; k < 8; k++) exp_code[k] = e[23:16];
        chk("R7 broadcast busy", busy, int'(e[15:0]));
        for (int k = 0; k < 8; k++)
          chk("R7 R9 capture order", int'(cap_log[cap_n - 8 + k]), k);
      end else begin
        exp_code[e[26:24]] = e[23:16];
        chk("R6 busy length", busy, int'(e[15:0]));
      end
      // R5 R8 R10 latch and shadow contents; shadow of unwritten channels is 0
      for (int k = 0; k < 8; k++) begin
        chk("R5 latch", lat[k], exp_code[k]);
        rd_chan = 3'(k); #0.1;
        chk("R8 R10 shadow", rd_code, (exp_code[k] == 8'hEE) ? 0 : exp_code[k]);
      end
    end

    chk("R2 min low width", low_min, LOW_E);
    chk("R2 max low width", low_max, LOW_E);
    chk("R2 pulse count", pulses, 7 + 8);
    chk("R3 setup violations", setup_viol, 0);
    chk("R3 low-period changes", low_viol, 0);
    chk("R4 hold violations", hold_viol, 0);

    // R1: reset during a broadcast abandons it and clears the shadows
    begin
      @(negedge clk);
      req_valid = 1; req_bcast = 1; req_code = 8'h5A;
      @(negedge clk); req_valid = 0;
      repeat (3 * WCYC) @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      chk("R1 strobe high in mid-run reset", dac_wr_n, 1);
      rst_n = 1;
      repeat (4) @(negedge clk);
      chk("R1 ready after mid-run reset", req_ready, 1);
      for (int k = 0; k < 8; k++) begin
        rd_chan = 3'(k); #0.1;
        chk("R1 shadow cleared", rd_code, 0);
      end
      repeat (2 * WCYC) @(negedge clk);
      chk("R1 no strobe after abandoned run", dac_wr_n, 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule